// File: doc/BRIEF.md
# Ordered Single-Precision Sum Reducer

This block folds a short vector of IEEE-754 single-precision values into one sum. It starts from a scalar seed, then adds the elements into an accumulator one per clock, from the lowest index to the highest. Every partial sum is rounded to nearest-even before the next add, so the result matches a strictly sequential evaluation and not a pairwise tree. A per-element enable mask can exclude lanes. An excluded lane feeds negative zero into the adder instead of its own value. Negative zero leaves every non-NaN accumulator value unchanged, including a negative-zero seed.

A request is taken with a one-cycle `start` while the unit is idle. The vector length, the mask, the seed and the elements are captured at that edge. The unit stays `busy` while it steps through the lanes, then pulses `done` for one cycle. `result` and `invalid` hold their values until the next request completes. When no lane is active (length zero, or every lane below the length masked off), no addition happens and the seed is returned bit for bit, NaN payload and sign included.

Top module: `fp_ordered_sum_red`

## Requirements
- R1: The result equals the seed plus the active elements, added in ascending index order, with a round-to-nearest-even step after each add.
- R2: A lane whose mask bit is 0 while `mask_en` is 1 has no effect on the result, whatever value it holds; a seed of -0.0 (0x80000000) with only -0.0 active elements yields 0x80000000.
- R3: If no lane is active, `result` equals `scalar_in` bit for bit (including NaN payloads and -0.0) and `invalid` is 0.
- R4: With `mask_en` 0 every lane below `vlen` is active regardless of `mask`; lanes at index `vlen` or above never take part.
- R5: Any NaN produced by an addition is output as 0x7FC00000; adding infinities of opposite sign sets `invalid`, which stays set for the rest of that request.
- R6: The sum of two finite values of equal magnitude and opposite sign is +0.0 (0x00000000); -0.0 plus -0.0 is -0.0.
- R7: Subnormal operands are added exactly before rounding, a sum beyond the largest finite value rounds to infinity of the proper sign, and an infinity operand passes to the sum.
- R8: `done` is high for exactly one cycle. It rises on the `vlen`-th clock edge after the edge that accepted `start` when some lane is active, and on the first such edge otherwise. `busy` is high from the accepting edge until `done` rises and is never high together with `done`.
- R9: A `start` raised while `busy` is 1 is ignored, and `result`/`invalid` keep their value while the unit is idle.
- R10: After reset `busy`, `done`, `invalid` are 0 and `result` is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, honoured only while idle |
| vlen | input | LEN_W (4) | Number of lanes to process, 0 to N_ELEM |
| mask_en | input | 1 | 1: apply `mask`; 0: all lanes below `vlen` active |
| mask | input | N_ELEM (8) | Per-lane enable, bit i gates lane i |
| scalar_in | input | 32 | Seed value of the accumulator |
| elems | input | N_ELEM*32 (256) | Packed lanes, lane i at bits [32*i+31:32*i] |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Final sum, held until the next completion |
| invalid | output | 1 | Invalid-operation flag of the last request |

## Verification
The properties assume the caller drives `vlen` no larger than the lane count and treats a start raised during `busy` as lost. The properties also assume that `result` may change only on the completion edge. The stimulus keeps `vlen` within 0 to 8 and waits for each completion before the next accepted request. The only deliberate violation is one extra `start` during a busy period, which the unit must drop. Expected sums come from a model that evaluates each pairwise add in double precision and rounds to single precision by explicit arithmetic. That model skips inactive lanes instead of feeding them negative zero, so the substitution scheme is checked against a separate formulation.

// File: rtl/fp_red_pkg.sv
package fp_red_pkg;

  localparam int FP_W  = 32;
  localparam int MAN_W = 23;
  localparam int EXT_W = MAN_W + 4;   // hidden bit + fraction + guard/round/sticky

  localparam logic [FP_W-1:0] NEG_ZERO   = 32'h8000_0000;
  localparam logic [FP_W-1:0] CANON_QNAN = 32'h7FC0_0000;

  typedef struct packed {
    logic            invalid;
    logic [FP_W-1:0] val;
  } fp_add_t;

  function automatic logic fp_is_nan(logic [FP_W-1:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
  endfunction

  function automatic logic fp_is_inf(logic [FP_W-1:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] == 23'd0);
  endfunction

  function automatic logic fp_is_zero(logic [FP_W-1:0] x);
    return x[30:0] == 31'd0;
  endfunction

  // Right shift of an extended mantissa, folding lost bits into bit 0.
  function automatic logic [EXT_W-1:0] shr_sticky(logic [EXT_W-1:0] m, logic [7:0] d);
    logic [EXT_W-1:0] kept;
    logic             lost;
    if (d >= 8'(EXT_W)) begin
      kept = '0;
      lost = |m;
    end else begin
      kept = m >> d;
      lost = |(m & ~({EXT_W{1'b1}} << d));
    end
    return {kept[EXT_W-1:1], kept[0] | lost};
  endfunction

  // Single-precision add, round to nearest even.
  function automatic fp_add_t fp32_add(logic [FP_W-1:0] a, logic [FP_W-1:0] b);
    fp_add_t          r;
    logic             a_big;
    logic [FP_W-1:0]  big, sml;
    logic [7:0]       eb, es;
    logic [EXT_W-1:0] mb, ms, nm;
    logic [EXT_W:0]   sum;
    logic [9:0]       e;
    logic             rnd;
    logic [24:0]      m25;
    r.invalid = 1'b0;
    r.val     = '0;
    if (fp_is_nan(a) || fp_is_nan(b)) begin
      r.val = CANON_QNAN;
    end else if (fp_is_inf(a) && fp_is_inf(b)) begin
      if (a[31] != b[31]) begin
        r.val     = CANON_QNAN;
        r.invalid = 1'b1;
      end else begin
        r.val = a;
      end
    end else if (fp_is_inf(a)) begin
      r.val = a;
    end else if (fp_is_inf(b)) begin
      r.val = b;
    end else if (fp_is_zero(a) && fp_is_zero(b)) begin
      r.val = {a[31] & b[31], 31'd0};
    end else if (fp_is_zero(a)) begin
      r.val = b;
    end else if (fp_is_zero(b)) begin
      r.val = a;
    end else begin
      a_big = (a[30:0] >= b[30:0]);
      big   = a_big ? a : b;
      sml   = a_big ? b : a;
      eb    = (big[30:23] == 8'd0) ? 8'd1 : big[30:23];
      es    = (sml[30:23] == 8'd0) ? 8'd1 : sml[30:23];
      mb    = {big[30:23] != 8'd0, big[22:0], 3'b000};
      ms    = {sml[30:23] != 8'd0, sml[22:0], 3'b000};
      ms    = shr_sticky(ms, eb - es);
      e     = {2'b00, eb};
      if (big[31] == sml[31]) begin
        sum = {1'b0, mb} + {1'b0, ms};
        if (sum[EXT_W]) begin
          nm = {sum[EXT_W:2], sum[1] | sum[0]};
          e  = e + 10'd1;
        end else begin
          nm = sum[EXT_W-1:0];
        end
      end else begin
        nm = mb - ms;
        for (int i = 0; i < EXT_W - 1; i++) begin
          if (!nm[EXT_W-1] && (e > 10'd1)) begin
            nm = nm << 1;
            e  = e - 10'd1;
          end
        end
      end
      if (nm == '0) begin
        r.val = 32'h0000_0000;
      end else begin
        rnd = nm[2] & (nm[1] | nm[0] | nm[3]);
        m25 = {1'b0, nm[EXT_W-1:3]} + {24'd0, rnd};
        if (m25[24]) begin
          m25 = m25 >> 1;
          e   = e + 10'd1;
        end
        if (e >= 10'd255) r.val = {big[31], 8'hFF, 23'd0};
        else              r.val = {big[31], m25[23] ? e[7:0] : 8'h00, m25[22:0]};
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/fp_red_act_gen.sv
module fp_red_act_gen #(
  parameter int N_ELEM = 8,
  parameter int LEN_W  = 4
) (
  input  logic [LEN_W-1:0]  vlen,
  input  logic              mask_en,
  input  logic [N_ELEM-1:0] mask,
  output logic [N_ELEM-1:0] act,
  output logic              any_act
);
  for (genvar g = 0; g < N_ELEM; g++) begin : g_lane
    assign act[g] = (LEN_W'(g) < vlen) && (!mask_en || mask[g]);
  end
  assign any_act = |act;
endmodule

// File: rtl/fp_red_lane_sel.sv
module fp_red_lane_sel
  import fp_red_pkg::*;
#(
  parameter int N_ELEM = 8,
  parameter int IDX_W  = 3
) (
  input  logic [N_ELEM*FP_W-1:0] elems,
  input  logic [N_ELEM-1:0]      act,
  input  logic [IDX_W-1:0]       idx,
  output logic [FP_W-1:0]        operand
);
  logic [FP_W-1:0] lane_op [N_ELEM];

  for (genvar g = 0; g < N_ELEM; g++) begin : g_sub
    assign lane_op[g] = act[g] ? elems[g*FP_W +: FP_W] : NEG_ZERO;
  end

  always_comb begin
    operand = NEG_ZERO;
    for (int i = 0; i < N_ELEM; i++) begin
      if (IDX_W'(i) == idx) operand = lane_op[i];
    end
  end
endmodule

// File: rtl/fp_red_adder.sv
module fp_red_adder
  import fp_red_pkg::*;
(
  input  logic [FP_W-1:0] acc,
  input  logic [FP_W-1:0] operand,
  output logic [FP_W-1:0] sum,
  output logic            add_invalid
);
  fp_add_t res;
  assign res         = fp32_add(acc, operand);
  assign sum         = res.val;
  assign add_invalid = res.invalid;
endmodule

// File: rtl/fp_red_ctrl.sv
module fp_red_ctrl #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             any_act,
  input  logic [IDX_W-1:0] last_idx,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             run_any,
  output logic             step_en,
  output logic             finish
);
  logic [IDX_W-1:0] last_q;

  assign step_en = busy & run_any;
  assign finish  = busy & (!run_any || (idx == last_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      run_any <= 1'b0;
      last_q  <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      idx     <= '0;
      run_any <= any_act;
      last_q  <= last_idx;
    end else if (finish) begin
      busy <= 1'b0;
    end else if (busy) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/fp_ordered_sum_red.sv
module fp_ordered_sum_red
  import fp_red_pkg::*;
#(
  parameter  int N_ELEM = 8,
  localparam int LEN_W  = $clog2(N_ELEM + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [LEN_W-1:0]       vlen,
  input  logic                   mask_en,
  input  logic [N_ELEM-1:0]      mask,
  input  logic [FP_W-1:0]        scalar_in,
  input  logic [N_ELEM*FP_W-1:0] elems,
  output logic                   busy,
  output logic                   done,
  output logic [FP_W-1:0]        result,
  output logic                   invalid
);
  localparam int IDX_W = (N_ELEM > 1) ? $clog2(N_ELEM) : 1;

  logic [N_ELEM-1:0]      act_w, act_q;
  logic                   any_w;
  logic [N_ELEM*FP_W-1:0] elems_q;
  logic [FP_W-1:0]        acc_q, operand, add_sum;
  logic                   add_inv, inv_run_q;
  logic [IDX_W-1:0]       idx, last_idx;
  logic                   accept, run_any, step_en, finish;
  logic [FP_W-1:0]        result_q;
  logic                   invalid_q, done_q;

  assign accept   = start & ~busy;
  assign last_idx = ((vlen == '0) || (vlen > LEN_W'(N_ELEM))) ? IDX_W'(N_ELEM - 1)
                                                               : IDX_W'(vlen - 1'b1);

  fp_red_act_gen #(.N_ELEM(N_ELEM), .LEN_W(LEN_W)) u_act (
    .vlen(vlen), .mask_en(mask_en), .mask(mask), .act(act_w), .any_act(any_w)
  );

  fp_red_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .any_act(any_w), .last_idx(last_idx),
    .busy(busy), .idx(idx), .run_any(run_any), .step_en(step_en), .finish(finish)
  );

  fp_red_lane_sel #(.N_ELEM(N_ELEM), .IDX_W(IDX_W)) u_sel (
    .elems(elems_q), .act(act_q), .idx(idx), .operand(operand)
  );

  fp_red_adder u_add (
    .acc(acc_q), .operand(operand), .sum(add_sum), .add_invalid(add_inv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elems_q   <= '0;
      act_q     <= '0;
      acc_q     <= '0;
      inv_run_q <= 1'b0;
      result_q  <= '0;
      invalid_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept) begin
        elems_q   <= elems;
        act_q     <= act_w;
        acc_q     <= scalar_in;
        inv_run_q <= 1'b0;
      end else if (step_en) begin
        acc_q     <= add_sum;
        inv_run_q <= inv_run_q | add_inv;
      end
      if (finish) begin
        result_q  <= run_any ? add_sum : acc_q;
        invalid_q <= run_any & (inv_run_q | add_inv);
      end
    end
  end

  assign done    = done_q;
  assign result  = result_q;
  assign invalid = invalid_q;
endmodule

// File: rtl/fp_red_chk.sv
module fp_red_chk #(
  parameter int N_ELEM = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [31:0] result,
  input logic        invalid,
  input logic        run_any,
  input logic [31:0] acc_q
);
  localparam int CNT_W = $clog2(N_ELEM + 2);
  logic [CNT_W-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));
  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  // R8
  busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (busy_run < CNT_W'(N_ELEM)));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(result) && $stable(invalid)));
  // R3
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !run_any) |-> ((result == acc_q) && !invalid));
  // R5
  invalid_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && invalid) |-> (result == 32'h7FC0_0000));
endmodule

bind fp_ordered_sum_red fp_red_chk #(.N_ELEM(N_ELEM)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .result(result), .invalid(invalid), .run_any(run_any), .acc_q(acc_q)
);

// File: tb/fp_ordered_sum_red_bench.sv
`timescale 1ns/1ps
module fp_ordered_sum_red_bench;
  localparam int N = 8;
  localparam logic [31:0] QNAN = 32'h7FC0_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    vlen = '0;
  logic          mask_en = 1'b0;
  logic [N-1:0]  mask = '0;
  logic [31:0]   scalar_in = '0;
  logic [N*32-1:0] elems = '0;
  logic          busy, done, invalid;
  logic [31:0]   result;

  always #4 clk = ~clk;

  fp_ordered_sum_red #(.N_ELEM(N)) u_fp_ordered_sum_red (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .mask_en(mask_en),
    .mask(mask), .scalar_in(scalar_in), .elems(elems), .busy(busy), .done(done),
    .result(result), .invalid(invalid)
  );

  typedef struct {
    logic [31:0] res;
    logic        inv;
    int          lat;
    int          stamp;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  exp_t        mon_e;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  logic [31:0] seed = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic real bits2real(logic [31:0] x);
    real m;
    int  ex;
    ex = int'(x[30:23]);
    if (ex == 0) m = real'(x[22:0]) * (2.0 ** (-149));
    else         m = (8388608.0 + real'(x[22:0])) * (2.0 ** (ex - 150));
    return x[31] ? -m : m;
  endfunction

  function automatic logic [31:0] real2bits(real v);
    logic        s;
    real         a, q, fl, fr;
    int          e;
    logic [31:0] mant;
    s = (v < 0.0);
    a = s ? -v : v;
    e = 0;
    while (a >= 2.0 ** (e + 1)) e++;
    while (a < 2.0 ** e) e--;
    if (e < -126) e = -126;
    q  = a / (2.0 ** (e - 23));
    fl = $floor(q);
    fr = q - fl;
    if (fr > 0.5 || (fr == 0.5 && (longint'(fl) % 2 == 1))) fl = fl + 1.0;
    if (fl >= 16777216.0) begin fl = fl / 2.0; e++; end
    if (e > 127) return {s, 8'hFF, 23'd0};
    mant = 32'(longint'(fl));
    if (mant[23]) return {s, 8'(e + 127), mant[22:0]};
    return {s, 8'h00, mant[22:0]};
  endfunction

  function automatic logic [31:0] ref_add(logic [31:0] a, logic [31:0] b, inout logic inv);
    bit  an, bn, ai, bi, az, bz;
    real s;
    an = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    bn = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    ai = (a[30:23] == 8'hFF) && (a[22:0] == 0);
    bi = (b[30:23] == 8'hFF) && (b[22:0] == 0);
    az = (a[30:0] == 0);
    bz = (b[30:0] == 0);
    if (an || bn) return QNAN;
    if (ai && bi) begin
      if (a[31] != b[31]) begin inv = 1'b1; return QNAN; end
      return a;
    end
    if (ai) return a;
    if (bi) return b;
    if (az && bz) return {a[31] & b[31], 31'd0};
    if (az) return b;
    if (bz) return a;
    s = bits2real(a) + bits2real(b);
    if (s == 0.0) return 32'h0;
    return real2bits(s);
  endfunction

  // ---------------- driver ----------------
  task automatic launch(logic [31:0] sc, logic [31:0] el[N], logic men,
                        logic [N-1:0] mk, int vl, string tag);
    exp_t        x;
    logic [31:0] acc;
    logic        inv, any;
    acc = sc; inv = 1'b0; any = 1'b0;
    for (int i = 0; i < vl; i++) begin
      if (!men || mk[i]) begin
        any = 1'b1;
        acc = ref_add(acc, el[i], inv);
      end
    end
    x.res = any ? acc : sc;
    x.inv = any ? inv : 1'b0;
    x.lat = any ? vl : 1;
    x.tag = tag;
    @(negedge clk);
    x.stamp = cyc + 1;
    sb_q.push_back(x);
    scalar_in = sc; mask_en = men; mask = mk; vlen = 4'(vl);
    for (int i = 0; i < N; i++) elems[i*32 +: 32] = el[i];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(logic [31:0] sc, logic [31:0] el[N], logic men,
                     logic [N-1:0] mk, int vl, string tag);
    launch(sc, el, men, mk, vl, tag);
    drain();
  endtask

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R8 unexpected done", {31'd0, done}, 32'd0);
      end else begin
        mon_e = sb_q.pop_front();
        chk(result == mon_e.res, {mon_e.tag, " result"}, result, mon_e.res);
        chk(invalid == mon_e.inv, {mon_e.tag, " invalid"}, {31'd0, invalid}, {31'd0, mon_e.inv});
        chk((cyc - mon_e.stamp) == mon_e.lat, {mon_e.tag, " R8 latency"},
            32'(cyc - mon_e.stamp), 32'(mon_e.lat));
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (cyc == 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] rnd_fp();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return {seed[31], 8'd120 + {4'd0, seed[27:24]}, seed[22:0]};
  endfunction

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] el[N];
    logic [31:0] held, tr;
    logic        dummy;

    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy == 1'b0, "R10 busy", {31'd0, busy}, 32'd0);
    chk(done == 1'b0, "R10 done", {31'd0, done}, 32'd0);
    chk(result == 32'd0, "R10 result", result, 32'd0);
    chk(invalid == 1'b0, "R10 invalid", {31'd0, invalid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 plain ordered sum
    el = '{32'h3F800000, 32'h40000000, 32'h40400000, 32'h40800000,
           32'h3E000000, 32'hBF000000, 32'h41200000, 32'hC1200000};
    run(32'h3F000000, el, 1'b0, 8'h00, 8, "R1 plain");

    // R1 ordered chain versus pairwise tree
    el = '{32'h3FC001E6, 32'h3FA01FFF, 32'h3FA01FFF, 32'h3FA01FFF, 0, 0, 0, 0};
    dummy = 1'b0;
    tr = ref_add(ref_add(el[0], el[1], dummy), ref_add(el[2], el[3], dummy), dummy);
    $display("info: tree-form value %h (not required)", tr);
    run(32'h00000000, el, 1'b0, 8'h00, 4, "R1 chain");

    // R1 per-step rounding: each tie to even keeps 1.0
    el = '{default: 32'h33800000};
    run(32'h3F800000, el, 1'b0, 8'h00, 8, "R1 ties");

    // R2/R3 all masked, seed -0.0
    el = '{default: 32'h3F800000};
    run(32'h80000000, el, 1'b1, 8'h00, 8, "R2 R3 neg-zero seed all masked");

    // R2 one active -0.0 lane, masked ones hold 1.0
    el[5] = 32'h80000000;
    run(32'h80000000, el, 1'b1, 8'h20, 8, "R2 neg-zero one lane");

    // R2 masked lanes hold huge values
    el = '{32'h7F000000, 32'h3F800000, 32'h7F800000, 32'h40000000,
           32'hFFC00001, 32'h3E800000, 32'h7F000000, 32'h40400000};
    run(32'h3F800000, el, 1'b1, 8'hAA, 8, "R2 masked huge");

    // R3 vlen zero with NaN seed payload
    run(32'h7FA12345, el, 1'b0, 8'hFF, 0, "R3 vlen0 nan");
    run(32'hFF812345, el, 1'b1, 8'h00, 5, "R3 masked snan");

    // R4 mask ignored when mask_en=0, lanes past vlen ignored
    el = '{32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h7F800000,
           32'hFF800000, 32'h7FC00000, 32'h7F800000, 32'h7F800000};
    run(32'h00000000, el, 1'b0, 8'h00, 3, "R4 vlen 3");

    // R5 inf + -inf then more adds
    el = '{32'hFF800000, 32'h3F800000, 32'h40000000, 0, 0, 0, 0, 0};
    run(32'h7F800000, el, 1'b0, 8'h00, 3, "R5 inf minus inf");
    // R5 NaN operand, no invalid
    el = '{32'h3F800000, 32'h7F800001, 32'h40000000, 0, 0, 0, 0, 0};
    run(32'h3F800000, el, 1'b0, 8'h00, 3, "R5 nan operand");

    // R6 cancellation and negative zeros
    el = '{32'hC0400000, 0, 0, 0, 0, 0, 0, 0};
    run(32'h40400000, el, 1'b0, 8'h00, 1, "R6 cancel");
    el = '{32'h80000000, 32'h80000000, 0, 0, 0, 0, 0, 0};
    run(32'h80000000, el, 1'b0, 8'h00, 2, "R6 neg zeros");

    // R7 subnormals, overflow, infinity operand
    el = '{32'h00000001, 32'h00000003, 32'h807FFFFF, 32'h00800000, 0, 0, 0, 0};
    run(32'h00400000, el, 1'b0, 8'h00, 4, "R7 subnormal");
    el = '{32'h7F7FFFFF, 32'h7F7FFFFF, 32'h3F800000, 0, 0, 0, 0, 0};
    run(32'h7F7FFFFF, el, 1'b0, 8'h00, 3, "R7 overflow");
    el = '{32'hFF800000, 32'h7F7FFFFF, 0, 0, 0, 0, 0, 0};
    run(32'h3F800000, el, 1'b0, 8'h00, 2, "R7 inf operand");

    // R9 start during busy is dropped, result held while idle
    el = '{default: 32'h40000000};
    launch(32'h3F800000, el, 1'b0, 8'h00, 8, "R9 first");
    @(negedge clk);
    scalar_in = 32'h12345678; vlen = 4'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    held = result;
    repeat (4) @(negedge clk);
    chk(result == held, "R9 hold", result, held);
    chk(busy == 1'b0, "R9 idle", {31'd0, busy}, 32'd0);

    // R1 random mix
    for (int k = 0; k < 30; k++) begin
      for (int i = 0; i < N; i++) el[i] = rnd_fp();
      run(rnd_fp(), el, seed[3], seed[15:8], int'(seed[19:16]) % 9, "R1 R2 R4 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule